// File: doc/BRIEF.md
# Ternary Table Key Extractor

The block derives a binary private key from three inputs: a 512-bit hash digest, a 512-bit masked word received from the far end, and a large table of random trits held outside the block. The digest is cut into 32 sixteen-bit fields. Each field is presented as an address on a synchronous table read port, and the port returns sixteen consecutive trits starting at that cell. These 512 trits are the candidates for the key. The secret selection mask comes from XORing the masked word with the digest. A mask-selected trit holding minus becomes key bit 0, and one holding plus becomes key bit 1. Trits that the mask leaves out are passed over, whatever value they hold.

A single start pulse captures the digest, the masked word and the key length, which is either 128 or 256 bits. The engine then consumes one table read per cycle until the key is full. If the mask points at a zero-valued cell, the result cannot be trusted, so the engine stops and flags an error. It does the same when the candidates run out before the key is full. The result stays on the outputs until the next accepted start.

Top module: `tkx_key_extract`

## Requirements
- R1: After reset, busy, done and err are low and the key output is all zeros.
- R2: Digest field k (bits 511-16k down to 496-16k) is used as the table address for the k-th read, for k = 0 to 31 in rising order. The port returns data one cycle after tblRdEn with tblAddr. Bits [2j+1:2j] of that data hold the cell at address+j modulo 65536.
- R3: The selection mask is the masked word XOR the digest. Candidate i = 16k+j (read k, trit j) is selected when mask bit 511-i is 1.
- R4: A selected trit coded 2'b01 (minus) appends key bit 0, and one coded 2'b10 (plus) appends key bit 1. Appended bits fill the key from bit 0 upward in candidate order.
- R5: An unselected candidate adds nothing to the key and raises no error, including when its cell holds 2'b00.
- R6: A selected candidate coded 2'b00 (zero) or 2'b11 (invalid) that is reached before the key is full ends the run with err high and done low.
- R7: keySel = 0 requests a 128-bit key, and bits 255:128 of the key output then stay zero. keySel = 1 requests a 256-bit key.
- R8: When the requested number of bits is appended, the run ends with done high and err low. Later candidates are not examined. done, err and key hold until the next accepted start.
- R9: If all 512 candidates are consumed before the key is full, the run ends with err high and done low.
- R10: A start pulse while busy is ignored. The run in progress keeps its latched digest, mask and key length.
- R11: A run that consumes B table reads raises done or err B+1 clock cycles after the edge that accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| keySel | input | 1 | Key length select: 0 = 128 bits, 1 = 256 bits |
| digest | input | 512 | Hash digest, the source of the table addresses |
| maskedWord | input | 512 | Received mask XOR digest |
| tblAddr | output | 16 | Table read address |
| tblRdEn | output | 1 | Table read strobe |
| tblData | input | 32 | Sixteen trits returned one cycle after the read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Key complete and valid |
| err | output | 1 | Run failed: a zero cell was selected or the candidates ran out |
| key | output | 256 | Extracted key, bit 0 filled first |

## Verification
A wrong fill count or a wrong mask alignment appears at the ports in three ways. The key differs from the reference. The run ends at a different cycle count than B+1. Or err appears where done was expected. All of these are visible on the cycle the run ends. A misaligned address shift is caught on the next read, because the bench models the table and its contents depend on the address. The bench builds masks that select exactly the nonzero cells, masks that starve the key, and masks that include one zero cell. Digests near the top of the address space exercise wrap-around. A second start during a run checks that the latched inputs are kept.

// File: rtl/tkx_pkg.sv
package tkx_pkg;
  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_NEG  = 2'b01;
  localparam logic [1:0] TRIT_POS  = 2'b10;

  typedef struct packed {
    logic latch;   // capture inputs, clear result
    logic first;   // address the first digest field
    logic absorb;  // consume the returned trit word
  } tkxStrobe_t;

  typedef struct packed {
    logic full;    // key reaches target in this word
    logic bad;     // selected zero/invalid trit reached first
    logic lastBlk; // word being consumed is the final one
  } tkxStatus_t;
endpackage

// File: rtl/tkx_ctrl.sv
module tkx_ctrl
  import tkx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  tkxStatus_t status,
  output tkxStrobe_t strobe,
  output logic       tblRdEn,
  output logic       busy,
  output logic       done,
  output logic       err
);
  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_RUN} state_t;
  state_t state, stateNxt;
  logic doneNxt, errNxt;

  always_comb begin
    stateNxt      = state;
    doneNxt       = done;
    errNxt        = err;
    strobe.latch  = 1'b0;
    strobe.first  = 1'b0;
    strobe.absorb = 1'b0;
    tblRdEn       = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.latch = 1'b1;
          doneNxt      = 1'b0;
          errNxt       = 1'b0;
          stateNxt     = S_FIRST;
        end
      end
      S_FIRST: begin
        strobe.first = 1'b1;
        tblRdEn      = 1'b1;
        stateNxt     = S_RUN;
      end
      S_RUN: begin
        strobe.absorb = 1'b1;
        tblRdEn       = !status.lastBlk;
        if (status.bad) begin
          errNxt   = 1'b1;
          stateNxt = S_IDLE;
        end else if (status.full) begin
          doneNxt  = 1'b1;
          stateNxt = S_IDLE;
        end else if (status.lastBlk) begin
          errNxt   = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
      err   <= errNxt;
    end
  end

  assign busy = (state != S_IDLE);

  // R6 / R8 / R9: a run ends either as success or as failure, never both
  a_r6_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R8: a finished result is only shown while idle
  a_r8_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  // R10: a start seen during a run does not restart it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && start && !status.bad && !status.full && !status.lastBlk)
      |=> state == S_RUN);
endmodule

// File: rtl/tkx_datapath.sv
module tkx_datapath
  import tkx_pkg::*;
#(
  parameter int DIG_W  = 512,
  parameter int ADDR_W = 16,
  parameter int TRITS  = 16,
  parameter int KEY_W  = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tkxStrobe_t          strobe,
  input  logic [DIG_W-1:0]    digest,
  input  logic [DIG_W-1:0]    maskedWord,
  input  logic                keySel,
  input  logic [2*TRITS-1:0]  tblData,
  output logic [ADDR_W-1:0]   tblAddr,
  output tkxStatus_t          status,
  output logic [KEY_W-1:0]    key
);
  localparam int BLOCKS = DIG_W / ADDR_W;
  localparam int BIDX_W = $clog2(BLOCKS);
  localparam int CNT_W  = $clog2(KEY_W) + 1;
  localparam int KIDX_W = $clog2(KEY_W);

  logic [DIG_W-1:0]  digSh;
  logic [DIG_W-1:0]  maskSh;
  logic              keySelQ;
  logic [CNT_W-1:0]  cnt, cntNxt, target;
  logic [KEY_W-1:0]  keyQ, keyNxt;
  logic [BIDX_W-1:0] blkIdx;
  logic              stopped, bad;

  assign target  = keySelQ ? CNT_W'(KEY_W) : CNT_W'(KEY_W / 2);
  assign tblAddr = strobe.first ? digSh[DIG_W-1 -: ADDR_W]
                                : digSh[DIG_W-1-ADDR_W -: ADDR_W];

  // Consume one word of trits in candidate order
  always_comb begin
    cntNxt  = cnt;
    keyNxt  = keyQ;
    stopped = 1'b0;
    bad     = 1'b0;
    for (int j = 0; j < TRITS; j++) begin
      if (!stopped && maskSh[DIG_W-1-j]) begin
        if (tblData[2*j +: 2] == TRIT_NEG || tblData[2*j +: 2] == TRIT_POS) begin
          keyNxt[cntNxt[KIDX_W-1:0]] = (tblData[2*j +: 2] == TRIT_POS);
          cntNxt = cntNxt + CNT_W'(1);
          if (cntNxt == target) stopped = 1'b1;
        end else begin
          bad     = 1'b1;
          stopped = 1'b1;
        end
      end
    end
  end

  assign status.bad     = bad;
  assign status.full    = !bad && (cntNxt == target);
  assign status.lastBlk = (blkIdx == BIDX_W'(BLOCKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digSh   <= '0;
      maskSh  <= '0;
      keySelQ <= 1'b0;
      cnt     <= '0;
      keyQ    <= '0;
      blkIdx  <= '0;
    end else if (strobe.latch) begin
      digSh   <= digest;
      maskSh  <= maskedWord ^ digest;
      keySelQ <= keySel;
      cnt     <= '0;
      keyQ    <= '0;
      blkIdx  <= '0;
    end else if (strobe.absorb) begin
      digSh   <= digSh << ADDR_W;
      maskSh  <= maskSh << TRITS;
      cnt     <= cntNxt;
      keyQ    <= keyNxt;
      blkIdx  <= blkIdx + BIDX_W'(1);
    end
  end

  assign key = keyQ;

  // R8: the fill count never passes the requested length
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= target);

  // R7: a short key leaves the upper half untouched
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !keySelQ |-> keyQ[KEY_W-1:KEY_W/2] == '0);

  // R2: each consumed word advances the address field by one block
  a_r2_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.absorb && !strobe.latch |=> blkIdx == $past(blkIdx) + BIDX_W'(1));
endmodule

// File: rtl/tkx_key_extract.sv
module tkx_key_extract
  import tkx_pkg::*;
#(
  parameter int DIG_W  = 512,
  parameter int ADDR_W = 16,
  parameter int TRITS  = 16,
  parameter int KEY_W  = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               keySel,
  input  logic [DIG_W-1:0]   digest,
  input  logic [DIG_W-1:0]   maskedWord,
  output logic [ADDR_W-1:0]  tblAddr,
  output logic               tblRdEn,
  input  logic [2*TRITS-1:0] tblData,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [KEY_W-1:0]   key
);
  tkxStrobe_t strobe;
  tkxStatus_t status;

  tkx_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .status  (status),
    .strobe  (strobe),
    .tblRdEn (tblRdEn),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  tkx_datapath #(
    .DIG_W  (DIG_W),
    .ADDR_W (ADDR_W),
    .TRITS  (TRITS),
    .KEY_W  (KEY_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .digest     (digest),
    .maskedWord (maskedWord),
    .keySel     (keySel),
    .tblData    (tblData),
    .tblAddr    (tblAddr),
    .status     (status),
    .key        (key)
  );

  // R2: the table is only read during a run
  a_r2_read_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    tblRdEn |-> busy);
endmodule

// File: tb/tkx_key_extract_bench.sv
module tkx_key_extract_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         keySel = 1'b0;
  logic [511:0] digest = '0;
  logic [511:0] maskedWord = '0;
  logic [15:0]  tblAddr;
  logic         tblRdEn;
  logic [31:0]  tblData = '0;
  logic         busy, done, err;
  logic [255:0] key;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic [31:0] seedT = 32'h1234_5678;

  always #4 clk = ~clk;

  tkx_key_extract u_tkx_key_extract (
    .clk(clk), .rst_n(rst_n), .start(start), .keySel(keySel),
    .digest(digest), .maskedWord(maskedWord),
    .tblAddr(tblAddr), .tblRdEn(tblRdEn), .tblData(tblData),
    .busy(busy), .done(done), .err(err), .key(key)
  );

  function automatic logic [1:0] cellCode(input logic [15:0] c);
    logic [31:0] h;
    int v;
    h = ({16'd0, c} * 32'd40503) ^ seedT;
    h = h ^ (h >> 7) ^ (h >> 13);
    v = int'(h % 32'd3);
    return (v == 0) ? 2'b00 : (v == 1) ? 2'b01 : 2'b10;
  endfunction

  // Synchronous table: data one cycle after the read strobe (R2)
  always @(posedge clk) begin
    if (tblRdEn)
      for (int j = 0; j < 16; j++)
        tblData[2*j +: 2] <= cellCode(tblAddr + 16'(j));
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      mismatched++;
      $display("FAIL R8 watchdog expired: actual cycles %0d expected < 50000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] mkDig(input int s, input bit wrap);
    logic [511:0] d;
    for (int b = 0; b < 32; b++)
      d[511-16*b -: 16] = wrap ? (16'hFFF0 + 16'(b % 16)) : 16'(b * 4099 + s * 257 + 11);
    return d;
  endfunction

  // mode 0: all; 1: nonzero only; 2: every other nonzero; 3: nonzero plus one zero
  function automatic logic [511:0] mkMask(input logic [511:0] dg, input int mode);
    logic [511:0] m;
    bit alt, used;
    logic [1:0] c;
    int idx;
    alt = 1'b0; used = 1'b0; m = '0;
    for (int b = 0; b < 32; b++)
      for (int j = 0; j < 16; j++) begin
        idx = 16*b + j;
        c = cellCode(dg[511-16*b -: 16] + 16'(j));
        case (mode)
          0: m[511-idx] = 1'b1;
          1: m[511-idx] = (c != 2'b00);
          2: if (c != 2'b00) begin m[511-idx] = alt; alt = !alt; end
          default: begin
            m[511-idx] = (c != 2'b00);
            if (c == 2'b00 && idx >= 20 && !used) begin m[511-idx] = 1'b1; used = 1'b1; end
          end
        endcase
      end
    return m;
  endfunction

  task automatic model(input logic [511:0] dg, input logic [511:0] mk, input logic ks,
                       output logic [255:0] k, output logic e, output int blocks);
    int n, tgt, idx;
    logic [1:0] c;
    bit fin;
    k = '0; e = 1'b0; n = 0; fin = 1'b0; blocks = 32;
    tgt = ks ? 256 : 128;
    for (int b = 0; b < 32 && !fin; b++) begin
      for (int j = 0; j < 16 && !fin; j++) begin
        idx = 16*b + j;
        if (mk[511-idx]) begin
          c = cellCode(dg[511-16*b -: 16] + 16'(j));
          if (c == 2'b01 || c == 2'b10) begin
            k[n] = (c == 2'b10); n++;
            if (n == tgt) fin = 1'b1;
          end else begin
            e = 1'b1; fin = 1'b1;
          end
        end
      end
      if (fin) blocks = b + 1;
    end
    if (!fin) e = 1'b1;
  endtask

  task automatic runCase(input string tag, input logic [511:0] dg, input logic [511:0] mk,
                         input logic ks, input bit poke);
    logic [255:0] ek;
    logic ee;
    int eb, n;
    model(dg, mk, ks, ek, ee, eb);
    @(negedge clk);
    digest = dg; maskedWord = mk ^ dg; keySel = ks; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!(done || err) && n < 100) begin
      if (poke && n == 1) begin
        start = 1'b1; keySel = !ks; digest = ~dg; maskedWord = '0;
      end
      if (poke && n == 2) begin
        start = 1'b0; keySel = ks; digest = dg; maskedWord = mk ^ dg;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    check({tag, " R8/R9/R6 outcome {done,err}"}, 256'({done, err}), 256'({!ee, ee}));
    check({tag, " R11 cycles to end"}, 256'(n), 256'(eb + 1));
    if (!ee) check({tag, " R4/R3 key value"}, key, ek);
    if (!ee && !ks) check({tag, " R7 upper half zero"}, 256'(key[255:128]), 256'(0));
    check({tag, " R8 idle after end"}, 256'(busy), 256'(0));
  endtask

  task automatic testReset();
    check("R1 busy", 256'(busy), 256'(0));
    check("R1 done", 256'(done), 256'(0));
    check("R1 err", 256'(err), 256'(0));
    check("R1 key", key, 256'(0));
  endtask

  task automatic testKey128();
    logic [511:0] d = mkDig(1, 1'b0);
    runCase("R4/R5 128b", d, mkMask(d, 1), 1'b0, 1'b0);
  endtask

  task automatic testKey256();
    logic [511:0] d = mkDig(2, 1'b0);
    runCase("R7 256b", d, mkMask(d, 1), 1'b1, 1'b0);
  endtask

  task automatic testStarved();
    logic [511:0] d = mkDig(3, 1'b0);
    runCase("R9 starved", d, mkMask(d, 2), 1'b1, 1'b0);
  endtask

  task automatic testZeroSel();
    logic [511:0] d = mkDig(4, 1'b0);
    runCase("R6 zero picked", d, mkMask(d, 3), 1'b1, 1'b0);
  endtask

  task automatic testAllOnes();
    logic [511:0] d = mkDig(5, 1'b0);
    runCase("R6 all-ones mask", d, mkMask(d, 0), 1'b0, 1'b0);
  endtask

  task automatic testWrap();
    logic [511:0] d = mkDig(6, 1'b1);
    runCase("R2 wrap", d, mkMask(d, 1), 1'b0, 1'b0);
  endtask

  task automatic testBusyStart();
    logic [511:0] d = mkDig(7, 1'b0);
    runCase("R10 start while busy", d, mkMask(d, 1), 1'b1, 1'b1);
  endtask

  task automatic testHold();
    logic [255:0] k0 = key;
    repeat (5) @(negedge clk);
    check("R8 result held", key, k0);
    check("R8 done held", 256'(done), 256'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testKey128();
    testHold();
    testKey256();
    testStarved();
    testZeroSel();
    testAllOnes();
    seedT = 32'h0BAD_F00D;
    testWrap();
    testBusyStart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule